// File: doc/BRIEF.md
# Output Data Clock Regulator

This block sits at the end of a receive chain. Bytes reach it one at a time, marked by a one-cycle `in_valid`, and the gaps between them vary with the code rate of the link. The block drives them onto an external transport port. The port can be byte-wide (parallel) or bit-wide (serial). Three configuration bits pick the behaviour, and a divider value sets the regulated output rate.

In pass-through mode the output follows the input timing directly. A byte shows up on the parallel port one cycle after it arrives. On the serial port, its bits leave MSB first on consecutive system clocks. In regulated mode every byte first goes through a 16-entry FIFO. The output then advances only on an evenly spaced tick, one every N system clocks. N is set slightly below the average input spacing, so some ticks find the FIFO empty; on those ticks the output is marked invalid. Regulated serial output offers two strobe conventions: a strobe that toggles once per valid bit, or a strobe that stays high while valid bits flow.

Top module: `out_regulator`

## Requirements
- R1: After reset, `out_data`, `out_bit`, `out_valid`, `out_strobe`, `out_tick` and `overflow` are all 0.
- R2: With `cfg_regulate`=0 and `cfg_serial`=0, a byte accepted with `in_valid` appears on `out_data` on the next cycle. `out_valid`, `out_strobe` and `out_tick` are high for exactly that one cycle, and `out_data` holds its value otherwise.
- R3: With `cfg_regulate`=0 and `cfg_serial`=1, an accepted byte is sent on `out_bit` MSB first, over the 8 cycles that follow. `out_valid`, `out_strobe` and `out_tick` are high on each of those cycles. A new byte that arrives during this sequence restarts it with the new byte.
- R4: With `cfg_regulate`=0, the value of `cfg_strobe_hold` has no effect on any output.
- R5: With `cfg_regulate`=1, the internal tick fires every N system clocks, where N = `cfg_div` and a value of 0 counts as 1. The first tick comes N clocks after the mode is entered. `out_tick` is high for one cycle after each tick, and `out_valid`, `out_strobe`, `out_data` and `out_bit` change only in that cycle.
- R6: With `cfg_regulate`=1, all output bytes come from a 16-byte FIFO, in the order they arrived.
- R7: Regulated parallel: each tick pops one byte to `out_data` with `out_valid`=1. If the FIFO is empty at the tick, `out_valid` goes to 0 and `out_data` holds its value.
- R8: Regulated serial: each byte takes 8 ticks, MSB first. The next byte is popped on the tick after its last bit. A tick that finds no bit to send drives `out_valid` to 0.
- R9: Regulated serial with `cfg_strobe_hold`=0: `out_strobe` inverts on every tick that carries a valid bit, and is unchanged on ticks without one.
- R10: Regulated serial with `cfg_strobe_hold`=1: `out_strobe` equals `out_valid`.
- R11: A byte that arrives while the FIFO holds 16 bytes is dropped, and `overflow` goes to 1. It stays at 1 until reset.
- R12: While `cfg_regulate`=0 the FIFO is kept empty, so bytes stored before leaving regulated mode are never output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_data | input | 8 | Incoming byte |
| in_valid | input | 1 | One-cycle strobe marking a byte on `in_data` |
| cfg_regulate | input | 1 | 1 selects regulated (FIFO) mode |
| cfg_strobe_hold | input | 1 | Regulated serial strobe style: 0 toggle, 1 level |
| cfg_serial | input | 1 | 1 selects the serial port, 0 the parallel port |
| cfg_div | input | DIV_W | Regulated tick period N in system clocks (0 treated as 1) |
| out_data | output | 8 | Parallel output byte |
| out_bit | output | 1 | Serial output bit |
| out_valid | output | 1 | Output carries real data |
| out_strobe | output | 1 | Data strobe |
| out_tick | output | 1 | Output clock pulse |
| overflow | output | 1 | Sticky FIFO overflow flag |

## Verification
Some properties hold on every cycle, and the assertions check those. Regulated outputs move only with `out_tick`. Ticks are never adjacent when N exceeds 1. Pass-through parallel output follows the previous input. The two strobe conventions keep their rules. `overflow` rises only on a regulated arrival and never falls. Other behaviours depend on history, and only the bench's reference model can show them: FIFO ordering, MSB-first serial bits, the restart of a serial byte in pass-through mode, the flush on leaving regulated mode, and which byte is lost on overflow. The model tracks each of these with a queue and compares every output on every clock.

// File: rtl/out_regulator.sv
module out_regulator #(
  parameter int DEPTH = 16,
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [7:0]       in_data,
  input  logic             in_valid,
  input  logic             cfg_regulate,
  input  logic             cfg_strobe_hold,
  input  logic             cfg_serial,
  input  logic [DIV_W-1:0] cfg_div,
  output logic [7:0]       out_data,
  output logic             out_bit,
  output logic             out_valid,
  output logic             out_strobe,
  output logic             out_tick,
  output logic             overflow
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = AW + 1;

  logic [7:0]       mem [DEPTH];
  logic [AW-1:0]    wp, rp;
  logic [CW-1:0]    fill;
  logic [DIV_W-1:0] div_q, last;
  logic [7:0]       sh;
  logic [2:0]       left;
  logic             tick, empty, full, pop, push, step, load_ser, shift, emit;
  logic [7:0]       src;

  assign last     = (cfg_div == '0) ? '0 : cfg_div - 1'b1;
  assign tick     = cfg_regulate && (div_q == last);
  assign empty    = (fill == '0);
  assign full     = (fill == CW'(DEPTH));
  assign pop      = tick && !empty && (!cfg_serial || left == 3'd0);
  assign push     = cfg_regulate && in_valid && !full;
  assign step     = !cfg_regulate || tick;
  assign src      = cfg_regulate ? mem[rp] : in_data;
  assign load_ser = cfg_serial && (cfg_regulate ? pop : in_valid);
  assign shift    = cfg_serial && !load_ser && step && (left != 3'd0);
  assign emit     = cfg_serial ? (load_ser || shift) : (cfg_regulate ? pop : in_valid);

  function automatic logic [AW-1:0] adv(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) div_q <= '0;
    else        div_q <= (!cfg_regulate || tick) ? '0 : div_q + 1'b1;

  always_ff @(posedge clk)
    if (push) mem[wp] <= in_data;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wp <= '0; rp <= '0; fill <= '0; overflow <= 1'b0;
    end else begin
      overflow <= overflow | (cfg_regulate && in_valid && full);
      if (!cfg_regulate) begin
        wp <= '0; rp <= '0; fill <= '0;
      end else begin
        if (push) wp <= adv(wp);
        if (pop)  rp <= adv(rp);
        fill <= fill + CW'(push) - CW'(pop);
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      out_data <= '0; out_bit <= 1'b0; sh <= '0; left <= '0;
      out_valid <= 1'b0; out_strobe <= 1'b0; out_tick <= 1'b0;
    end else begin
      if (!cfg_serial && emit) out_data <= src;
      if (load_ser) begin
        out_bit <= src[7];
        sh      <= {src[6:0], 1'b0};
        left    <= 3'd7;
      end else if (shift) begin
        out_bit <= sh[7];
        sh      <= {sh[6:0], 1'b0};
        left    <= left - 1'b1;
      end
      if (step) begin
        out_valid <= emit;
        if (cfg_regulate && cfg_serial && !cfg_strobe_hold) out_strobe <= out_strobe ^ emit;
        else                                                out_strobe <= emit;
      end
      out_tick <= cfg_regulate ? tick : emit;
    end
endmodule

// File: rtl/out_regulator_checker.sv
module out_regulator_checker #(
  parameter int DIV_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [7:0]       in_data,
  input logic             in_valid,
  input logic             cfg_regulate,
  input logic             cfg_strobe_hold,
  input logic             cfg_serial,
  input logic [DIV_W-1:0] cfg_div,
  input logic [7:0]       out_data,
  input logic             out_valid,
  input logic             out_strobe,
  input logic             out_tick,
  input logic             overflow
);
  assert_passthru_byte_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!cfg_regulate && !cfg_serial && in_valid) |-> out_valid && out_data == $past(in_data));

  assert_moves_on_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cfg_regulate) && !out_tick |-> $stable(out_valid) && $stable(out_strobe) && $stable(out_data));

  assert_tick_spacing_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cfg_regulate) && cfg_regulate && out_tick && cfg_div > 1 |=> !out_tick);

  assert_strobe_toggle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cfg_regulate && cfg_serial && !cfg_strobe_hold) && out_tick |->
      (out_valid ? (out_strobe != $past(out_strobe)) : $stable(out_strobe)));

  assert_strobe_level_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cfg_regulate && cfg_serial && cfg_strobe_hold) && out_tick |-> out_strobe == out_valid);

  assert_overflow_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);

  assert_overflow_cause_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overflow) |-> $past(cfg_regulate && in_valid));
endmodule

bind out_regulator out_regulator_checker #(.DIV_W(DIV_W)) u_check (
  .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_valid(in_valid),
  .cfg_regulate(cfg_regulate), .cfg_strobe_hold(cfg_strobe_hold),
  .cfg_serial(cfg_serial), .cfg_div(cfg_div), .out_data(out_data),
  .out_valid(out_valid), .out_strobe(out_strobe), .out_tick(out_tick),
  .overflow(overflow));

// File: tb/out_regulator_bench.sv
module out_regulator_bench;
  logic       clk = 0, rst_n = 0;
  logic [7:0] in_data = 0;
  logic       in_valid = 0, cfg_regulate = 0, cfg_strobe_hold = 0, cfg_serial = 0;
  logic [7:0] cfg_div = 0;
  logic [7:0] out_data;
  logic       out_bit, out_valid, out_strobe, out_tick, overflow;

  int tests = 0, fails = 0;
  string cur_req = "R1";
  bit running = 0;

  always #5 clk = ~clk;

  out_regulator u_out_regulator (.*);

  // behavioural reference model
  logic [7:0] m_data, m_sh;
  logic       m_bit, m_valid, m_strobe, m_tick, m_ovf;
  int         m_left, m_div;
  logic [7:0] q[$];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_data = 0; m_sh = 0; m_bit = 0; m_valid = 0; m_strobe = 0; m_tick = 0;
      m_ovf = 0; m_left = 0; m_div = 0; q.delete();
    end else begin
      int n; bit tk, pop, full, step, emit, ld; logic [7:0] src;
      n    = (cfg_div == 0) ? 1 : int'(cfg_div);
      tk   = cfg_regulate && (m_div == n - 1);
      m_div = (!cfg_regulate || tk) ? 0 : m_div + 1;
      full = (q.size() == 16);
      pop  = tk && q.size() > 0 && (!cfg_serial || m_left == 0);
      src  = cfg_regulate ? ((q.size() > 0) ? q[0] : 8'h00) : in_data;
      step = !cfg_regulate || tk;
      emit = 0;
      if (!cfg_serial) begin
        emit = cfg_regulate ? pop : in_valid;
        if (emit) m_data = src;
      end else begin
        ld = cfg_regulate ? pop : in_valid;
        if (ld) begin
          m_bit = src[7]; m_sh = src << 1; m_left = 7; emit = 1;
        end else if (step && m_left != 0) begin
          m_bit = m_sh[7]; m_sh = m_sh << 1; m_left--; emit = 1;
        end
      end
      if (step) begin
        m_valid = emit;
        m_strobe = (cfg_regulate && cfg_serial && !cfg_strobe_hold) ? (m_strobe ^ emit) : emit;
      end
      m_tick = cfg_regulate ? tk : emit;
      if (pop) void'(q.pop_front());
      if (!cfg_regulate) q.delete();
      else if (in_valid) begin
        if (full) m_ovf = 1;
        else q.push_back(in_data);
      end
    end
  end

  always @(negedge clk) if (rst_n && running) begin
    logic [12:0] act, exp;
    act = {out_data, out_bit, out_valid, out_strobe, out_tick, overflow};
    exp = {m_data, m_bit, m_valid, m_strobe, m_tick, m_ovf};
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s t=%0t actual=%h expected=%h", cur_req, $time, act, exp);
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset(input bit reg_en, input bit ser, input bit hold, input int div);
    @(negedge clk);
    running = 0; rst_n = 0; in_valid = 0;
    cfg_regulate = reg_en; cfg_serial = ser; cfg_strobe_hold = hold; cfg_div = 8'(div);
    repeat (2) @(negedge clk);
    rst_n = 1; running = 1;
  endtask

  task automatic send(input int nbytes, input int mingap, input int maxgap, input bit flip_hold);
    for (int i = 0; i < nbytes; i++) begin
      in_valid = 1; in_data = 8'($urandom_range(0, 255));
      if (flip_hold) cfg_strobe_hold = 1'($urandom_range(0, 1));
      @(negedge clk);
      in_valid = 0;
      repeat ($urandom_range(mingap, maxgap)) @(negedge clk);
    end
  endtask

  initial begin
    #1_500_000;
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    do_reset(0, 0, 0, 1);
    // R1: reset values
    check("R1", {out_data, out_bit, out_valid, out_strobe, out_tick, overflow}, 0);

    cur_req = "R2/R4";                    // pass-through parallel, hold bit flipping
    send(40, 0, 4, 1);
    repeat (5) @(negedge clk);

    cur_req = "R3/R4";                    // pass-through serial, incl. restarts
    cfg_serial = 1;
    send(20, 8, 12, 1);
    send(6, 2, 5, 1);
    repeat (12) @(negedge clk);

    do_reset(1, 0, 0, 3);                 // R5/R7 regulated parallel
    cur_req = "R5/R7";
    send(60, 1, 5, 0);
    repeat (30) @(negedge clk);

    do_reset(1, 0, 0, 20);                // R6/R11 fill past depth
    cur_req = "R6/R11";
    send(22, 0, 0, 0);
    check("R11", overflow, 1);
    repeat (400) @(negedge clk);
    check("R11", overflow, 1);

    do_reset(1, 1, 0, 2);                 // R8/R9 serial toggle strobe
    cur_req = "R8/R9";
    send(25, 10, 24, 0);
    repeat (60) @(negedge clk);

    do_reset(1, 1, 1, 0);                 // R10, N=0 acts as 1
    cur_req = "R5/R10";
    send(25, 4, 12, 0);
    repeat (30) @(negedge clk);

    do_reset(1, 0, 0, 10);                // R12 flush on leaving regulated mode
    cur_req = "R12";
    send(5, 0, 0, 0);
    cfg_regulate = 0;
    repeat (6) @(negedge clk);
    cfg_regulate = 1;
    send(2, 0, 0, 0);
    repeat (40) @(negedge clk);
    check("R12", out_valid, 0);

    running = 0;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule